// File: doc/BRIEF.md
# User-Mode Dummy Cycle Injector

This block sits between the software-driven user-mode write path of a SPI flash controller and the byte shifter that drives the flash. Software pushes command, address and data bytes by hand in user mode. It often leaves out the dummy bytes that fast-read style commands need between the address and the data. The injector watches the bytes written after the chip select is asserted. It treats the first byte as a flash opcode and looks up how many dummy units that opcode needs. When the address phase is complete, it sends the dummy bytes on its own.

Every write that is let through goes out on the SPI byte handshake, one byte at a time, least significant byte first. The bus write that arrives at the moment the dummy phase begins is not forwarded. In its place the injector sends the whole dummy sequence, filled with the value held in the dummy-fill input. The write is stalled until the last byte has been sent, and completion is then marked by a one-cycle pulse. When the write-enable bit of the selected chip is clear, a write sends nothing and leaves the tracking state as it was.

Top module: `smc_dummy_snooper`

## Requirements
- R1: While reset is held, and after it, `spi_valid` and `wr_ready` are low. After reset, snooping is off until the chip select rises, so an opcode byte written before that point passes through with no dummies.
- R2: A write that is let through sends exactly `wr_size` bytes (1 to 4), starting with `wr_data[7:0]` and moving upward. `wr_ready` pulses high for one cycle after the last byte, and never while `spi_valid` is high.
- R3: A rising edge on `cs_active` arms snooping. The low byte of the next accepted write is then decoded as the opcode, and that write itself passes through unchanged.
- R4: Opcodes 0x03, 0x02, 0xA2, 0x32, 0x13, 0x12 and 0x34 need zero dummies, and every opcode not in the table is treated the same way. Either case turns snooping off, so the writes that follow pass through unchanged.
- R5: Opcodes 0x0B, 0x3B, 0x6B, 0x3C and 0x6C need one unit. One unit is 8 dummy bytes.
- R6: Opcodes 0xBB, 0x0C and 0xBC need two units (16 bytes). Opcodes 0xEB and 0xEC need four units (32 bytes).
- R7: Each write that passes through adds its byte count to a byte index, starting from 0 at the opcode. The dummy phase starts with the first write that arrives when the index is at least 4, or at least 5 when `addr_4byte` is high.
- R8: In the dummy phase, every dummy byte equals `dummy_fill`, and none of the triggering write's data is sent. Snooping then turns off, so later writes pass through unchanged.
- R9: A falling edge on `cs_active` turns snooping off and drops any pending dummies.
- R10: When `cs_write_en` is low, a write sends no byte, still completes with a `wr_ready` pulse, and leaves the byte index unchanged.
- R11: While `spi_valid` is high and `spi_ready` is low, `spi_valid` stays high and `spi_data` stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_active | input | 1 | Chip select asserted level |
| cs_write_en | input | 1 | Write-enable bit of the selected chip |
| addr_4byte | input | 1 | Address phase is 4 bytes (else 3) |
| dummy_fill | input | 8 | Value placed in every dummy byte |
| wr_valid | input | 1 | User-mode write request, held until `wr_ready` |
| wr_data | input | DATA_W | Write data, low byte first |
| wr_size | input | SIZE_W | Bytes in the write, 1 to DATA_W/8 |
| wr_ready | output | 1 | One-cycle completion pulse for the write |
| spi_valid | output | 1 | Byte offered to the shifter |
| spi_data | output | 8 | Byte value |
| spi_ready | input | 1 | Shifter takes the byte this cycle |

## Verification
The assertions assume three things about the inputs. `dummy_fill` holds still while a dummy sequence is being sent. `cs_active` changes only while no write is in flight. `wr_valid` with its data and size is held steady until the completion pulse. The stimulus meets all three. It changes chip select, fill value, address width and write-enable only on a falling clock edge between writes, after the previous completion pulse has been seen. `spi_ready` is toggled pseudo-randomly throughout, so every byte sequence meets backpressure.

// File: rtl/smc_snoop_pkg.sv
// Shared constants and types for the user-mode dummy cycle injector.
// Assumes the snoop index never needs more than 8 bits.
package smc_snoop_pkg;

    localparam logic [7:0] IDX_OFF   = 8'hFF;
    localparam logic [7:0] IDX_START = 8'h00;

    typedef enum logic [1:0] {
        EM_IDLE = 2'd0,
        EM_SEND = 2'd1,
        EM_DONE = 2'd2
    } emit_state_t;

endpackage

// File: rtl/snoop_opcode_lut.sv
// Fixed opcode table: returns the number of dummy units a flash opcode
// needs. Unknown opcodes return 0, the same as commands without dummies.
module snoop_opcode_lut (
    input  logic [7:0] opcode,
    output logic [2:0] units
);

    // Purpose: map an opcode to its dummy unit count.
    always_comb begin
        unique case (opcode)
            8'h0B, 8'h3B, 8'h6B, 8'h3C, 8'h6C: units = 3'd1;
            8'hBB, 8'h0C, 8'hBC:               units = 3'd2;
            8'hEB, 8'hEC:                      units = 3'd4;
            default:                           units = 3'd0;
        endcase
    end

endmodule

// File: rtl/snoop_tracker.sv
// Byte index tracker. It follows chip-select edges and the writes that
// are accepted, and decides whether the current write starts the dummy
// phase. It assumes cs_active does not change while a write is in flight.
module snoop_tracker
    import smc_snoop_pkg::*;
#(
    parameter int SIZE_W = 3,
    parameter int UNIT   = 8,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_active,
    input  logic              addr_4byte,
    input  logic              take,
    input  logic [2:0]        units,
    input  logic [SIZE_W-1:0] size,
    output logic              do_dummy,
    output logic [CNT_W-1:0]  dummy_count
);

    logic [7:0]       idx_q;
    logic [CNT_W-1:0] pend_q;
    logic             cs_q;
    logic             snoop_off;
    logic             at_start;
    logic [7:0]       trig_idx;
    logic [7:0]       idx_next;

    // Purpose: classify the current index against the address width.
    always_comb begin
        snoop_off   = (idx_q == IDX_OFF);
        at_start    = (idx_q == IDX_START);
        trig_idx    = addr_4byte ? 8'd5 : 8'd4;
        do_dummy    = !snoop_off && !at_start && (idx_q >= trig_idx);
        dummy_count = pend_q;
        idx_next    = idx_q + 8'(size);
    end

    // Purpose: update the index and the pending dummy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= IDX_OFF;
            pend_q <= '0;
            cs_q   <= 1'b0;
        end else begin
            cs_q <= cs_active;
            if (cs_active && !cs_q) begin
                idx_q  <= IDX_START;
                pend_q <= '0;
            end else if (!cs_active && cs_q) begin
                idx_q  <= IDX_OFF;
                pend_q <= '0;
            end else if (take && !snoop_off) begin
                if (at_start) begin
                    if (units == 3'd0) begin
                        idx_q <= IDX_OFF;
                    end else begin
                        pend_q <= CNT_W'(units) * CNT_W'(UNIT);
                        idx_q  <= idx_next;
                    end
                end else if (do_dummy) begin
                    idx_q  <= IDX_OFF;
                    pend_q <= '0;
                end else begin
                    idx_q <= idx_next;
                end
            end
        end
    end

endmodule

// File: rtl/snoop_byte_emitter.sv
// Sends a run of bytes on a valid/ready handshake. The bytes are either the
// low bytes of a word or a repeated fill value. A one-cycle done pulse
// follows the last byte. A zero-length run goes straight to done.
module snoop_byte_emitter
    import smc_snoop_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  start_cnt,
    input  logic              start_dummy,
    input  logic [DATA_W-1:0] start_word,
    input  logic [7:0]        start_fill,
    output logic              idle,
    output logic              done,
    output logic              spi_valid,
    output logic [7:0]        spi_data,
    input  logic              spi_ready
);

    emit_state_t       state_q;
    logic [CNT_W-1:0]  left_q;
    logic [DATA_W-1:0] word_q;
    logic [7:0]        fill_q;
    logic              dummy_q;

    // Purpose: drive the handshake outputs from the state.
    always_comb begin
        idle      = (state_q == EM_IDLE);
        done      = (state_q == EM_DONE);
        spi_valid = (state_q == EM_SEND);
        spi_data  = dummy_q ? fill_q : word_q[7:0];
    end

    // Purpose: sequence the byte run and count the bytes left.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= EM_IDLE;
            left_q  <= '0;
            word_q  <= '0;
            fill_q  <= '0;
            dummy_q <= 1'b0;
        end else begin
            unique case (state_q)
                EM_IDLE: begin
                    if (start) begin
                        left_q  <= start_cnt;
                        word_q  <= start_word;
                        fill_q  <= start_fill;
                        dummy_q <= start_dummy;
                        state_q <= (start_cnt == '0) ? EM_DONE : EM_SEND;
                    end
                end
                EM_SEND: begin
                    if (spi_ready) begin
                        word_q <= word_q >> 8;
                        left_q <= left_q - 1'b1;
                        if (left_q == CNT_W'(1)) begin
                            state_q <= EM_DONE;
                        end
                    end
                end
                default: begin
                    state_q <= EM_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/smc_dummy_snooper.sv
// User-mode dummy cycle injector, top level. It accepts one write at a
// time and asks the tracker whether that write passes through, starts the
// dummy phase, or is ignored. It then hands the chosen byte run to the
// emitter. Assumes wr_valid/data/size stay steady until wr_ready.
module smc_dummy_snooper #(
    parameter int DATA_W = 32,
    parameter int UNIT   = 8,
    localparam int BYTES  = DATA_W / 8,
    localparam int SIZE_W = $clog2(BYTES + 1),
    localparam int CNT_W  = $clog2(4 * UNIT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_active,
    input  logic              cs_write_en,
    input  logic              addr_4byte,
    input  logic [7:0]        dummy_fill,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SIZE_W-1:0] wr_size,
    output logic              wr_ready,
    output logic              spi_valid,
    output logic [7:0]        spi_data,
    input  logic              spi_ready
);

    logic             em_idle;
    logic             em_done;
    logic             take_any;
    logic             take;
    logic [2:0]       units;
    logic             do_dummy;
    logic [CNT_W-1:0] dummy_count;
    logic [CNT_W-1:0] run_len;
    logic             run_dummy;

    // Purpose: decide the byte run for the write being accepted.
    always_comb begin
        take_any  = em_idle && wr_valid;
        take      = take_any && cs_write_en;
        run_dummy = cs_write_en && do_dummy;
        if (!cs_write_en) begin
            run_len = '0;
        end else if (do_dummy) begin
            run_len = dummy_count;
        end else begin
            run_len = CNT_W'(wr_size);
        end
        wr_ready = em_done;
    end

    snoop_opcode_lut u_lut (
        .opcode (wr_data[7:0]),
        .units  (units)
    );

    snoop_tracker #(
        .SIZE_W (SIZE_W),
        .UNIT   (UNIT),
        .CNT_W  (CNT_W)
    ) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_active   (cs_active),
        .addr_4byte  (addr_4byte),
        .take        (take),
        .units       (units),
        .size        (wr_size),
        .do_dummy    (do_dummy),
        .dummy_count (dummy_count)
    );

    snoop_byte_emitter #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_emit (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (take_any),
        .start_cnt   (run_len),
        .start_dummy (run_dummy),
        .start_word  (wr_data),
        .start_fill  (dummy_fill),
        .idle        (em_idle),
        .done        (em_done),
        .spi_valid   (spi_valid),
        .spi_data    (spi_data),
        .spi_ready   (spi_ready)
    );

endmodule

// File: rtl/smc_dummy_snooper_chk.sv
// Assertion checker for the dummy cycle injector, bound to its top.
// Assumes dummy_fill is steady while a dummy run is in progress.
module smc_dummy_snooper_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_active,
    input logic       wr_ready,
    input logic       spi_valid,
    input logic       spi_ready,
    input logic [7:0] spi_data,
    input logic [7:0] dummy_fill,
    input logic       tx_dummy,
    input logic       snoop_off
);

    logic rst_seen_q;

    // Purpose: remember the reset level of the previous cycle.
    always_ff @(posedge clk) begin
        rst_seen_q <= rst_n;
    end

    // Purpose: outputs are quiet in the cycle after reset is held (R1).
    always_ff @(posedge clk) begin
        if (rst_seen_q == 1'b0) begin
            p_quiet_reset_r1: assert (!spi_valid && !wr_ready)
                else $error("R1: output active after reset");
        end
    end

    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |=> !wr_ready);

    p_done_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> !spi_valid);

    p_fill_value_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_valid && tx_dummy) |-> (spi_data == dummy_fill));

    p_cs_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_active) |=> snoop_off);

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_valid && !spi_ready) |=> (spi_valid && $stable(spi_data)));

endmodule

bind smc_dummy_snooper smc_dummy_snooper_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_active  (cs_active),
    .wr_ready   (wr_ready),
    .spi_valid  (spi_valid),
    .spi_ready  (spi_ready),
    .spi_data   (spi_data),
    .dummy_fill (dummy_fill),
    .tx_dummy   (u_emit.dummy_q),
    .snoop_off  (u_track.snoop_off)
);

// File: tb/smc_dummy_snooper_bench.sv
// Scoreboard bench for the dummy cycle injector.
module smc_dummy_snooper_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_active = 1'b0;
    logic        cs_write_en = 1'b1;
    logic        addr_4byte = 1'b0;
    logic [7:0]  dummy_fill = 8'h00;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic [2:0]  wr_size = 3'd1;
    logic        wr_ready;
    logic        spi_valid;
    logic [7:0]  spi_data;
    logic        spi_ready = 1'b1;

    int          n_checks = 0;
    int          n_fail = 0;
    logic [7:0]  exp_q[$];
    string       cur_req = "R1";
    logic [7:0]  lfsr = 8'hA7;
    logic        prev_stall = 1'b0;
    logic [7:0]  prev_data = 8'h00;

    always #4 clk = ~clk;

    smc_dummy_snooper u_smc_dummy_snooper (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_active   (cs_active),
        .cs_write_en (cs_write_en),
        .addr_4byte  (addr_4byte),
        .dummy_fill  (dummy_fill),
        .wr_valid    (wr_valid),
        .wr_data     (wr_data),
        .wr_size     (wr_size),
        .wr_ready    (wr_ready),
        .spi_valid   (spi_valid),
        .spi_data    (spi_data),
        .spi_ready   (spi_ready)
    );

    // Pseudo-random backpressure, driven after the edge.
    always @(posedge clk) begin
        lfsr      <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        spi_ready <= lfsr[0] | lfsr[2];
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on every byte handshake; R11 stability.
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall) begin
                check(spi_valid && spi_data == prev_data, "R11", "held byte",
                      {23'd0, spi_valid, spi_data}, {24'd1, prev_data});
            end
            prev_stall = spi_valid && !spi_ready;
            prev_data  = spi_data;
            if (spi_valid && spi_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, cur_req, "unexpected byte", spi_data, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(spi_data == e, cur_req, "byte", spi_data, e);
                end
            end
        end
    end

    // Driver: nd = 0 pass-through, nd > 0 dummy run, nd < 0 ignored.
    task automatic wr(input logic [31:0] d, input int sz, input int nd,
                      input string req);
        cur_req = req;
        if (nd == 0) begin
            for (int i = 0; i < sz; i++) exp_q.push_back(d[8*i +: 8]);
        end else if (nd > 0) begin
            for (int i = 0; i < nd; i++) exp_q.push_back(dummy_fill);
        end
        @(negedge clk);
        wr_data  = d;
        wr_size  = 3'(sz);
        wr_valid = 1'b1;
        do @(negedge clk); while (!wr_ready);
        wr_valid = 1'b0;
        check(exp_q.size() == 0, req, "bytes left at completion",
              exp_q.size(), 0);
        exp_q.delete();
    endtask

    task automatic cs_set(input logic v);
        @(negedge clk);
        cs_active = v;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] zops[8] = '{8'h03, 8'h02, 8'hA2, 8'h32, 8'h13, 8'h12, 8'h34, 8'h9F};
        logic [7:0] dops[10] = '{8'h0B, 8'h3B, 8'h6B, 8'h3C, 8'h6C,
                                 8'hBB, 8'h0C, 8'hBC, 8'hEB, 8'hEC};
        int         dcnt[10] = '{8, 8, 8, 8, 8, 16, 16, 16, 32, 32};

        // R1: quiet outputs during reset.
        repeat (3) @(negedge clk);
        check(!spi_valid && !wr_ready, "R1", "outputs in reset",
              {spi_valid, wr_ready}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!spi_valid && !wr_ready, "R1", "outputs after reset",
              {spi_valid, wr_ready}, 0);

        // R1: snooping off after reset, opcode passes with no dummies.
        dummy_fill = 8'h5A;
        wr(32'h0B, 1, 0, "R1");
        wr(32'h00112233, 3, 0, "R1");
        wr(32'hDE, 1, 0, "R1");

        // R2: plain pass-through of several sizes.
        wr(32'h44332211, 4, 0, "R2");
        wr(32'h000000A5, 1, 0, "R2");
        wr(32'h0000BEEF, 2, 0, "R2");

        // R3, R5, R8: armed on select, 3-byte address, dummies then off.
        cs_set(1'b1);
        wr(32'h0B, 1, 0, "R3");
        wr(32'h00563412, 3, 0, "R3");
        wr(32'h0000DEAD, 2, 8, "R5");
        wr(32'h77, 1, 0, "R8");
        cs_set(1'b0);

        // R6: opcode and address in one 4-byte write, then 16 dummies.
        dummy_fill = 8'hC3;
        cs_set(1'b1);
        wr(32'h563412BB, 4, 0, "R6");
        wr(32'hFF, 1, 16, "R6");
        wr(32'h31, 1, 0, "R8");
        cs_set(1'b0);

        // R7: 4-byte address needs index 5 before the dummy phase.
        addr_4byte = 1'b1;
        dummy_fill = 8'h96;
        cs_set(1'b1);
        wr(32'h3C, 1, 0, "R7");
        wr(32'h00112233, 3, 0, "R7");
        wr(32'h99, 1, 0, "R7");
        wr(32'h55, 1, 8, "R7");
        cs_set(1'b0);
        cs_set(1'b1);
        wr(32'hEC, 1, 0, "R6");
        wr(32'h44332211, 4, 0, "R6");
        wr(32'h12, 1, 32, "R6");
        cs_set(1'b0);
        addr_4byte = 1'b0;

        // R4: zero-dummy and unknown opcodes turn snooping off.
        for (int k = 0; k < 8; k++) begin
            cs_set(1'b1);
            wr({24'd0, zops[k]}, 1, 0, "R4");
            wr(32'h00ABCDEF, 3, 0, "R4");
            wr(32'h42, 1, 0, "R4");
            wr(32'h4321, 2, 0, "R4");
            cs_set(1'b0);
        end

        // R5, R6: every dummy opcode with its byte count.
        for (int k = 0; k < 10; k++) begin
            dummy_fill = 8'(8'h11 * k + 8'h07);
            cs_set(1'b1);
            wr({8'h00, 8'h10, 8'h20, dops[k]}, 4, 0, (dcnt[k] == 8) ? "R5" : "R6");
            wr(32'hCAFE, 2, dcnt[k], (dcnt[k] == 8) ? "R5" : "R6");
            cs_set(1'b0);
        end

        // R9: deselect drops pending dummies.
        cs_set(1'b1);
        wr(32'h0B, 1, 0, "R9");
        wr(32'h00112233, 3, 0, "R9");
        cs_set(1'b0);
        wr(32'h66, 1, 0, "R9");
        wr(32'h6677, 2, 0, "R9");

        // R10: ignored writes send nothing and leave the index alone.
        dummy_fill = 8'h3E;
        cs_set(1'b1);
        cs_write_en = 1'b0;
        wr(32'h0B, 1, -1, "R10");
        cs_write_en = 1'b1;
        wr(32'h0B, 1, 0, "R10");
        wr(32'h00112233, 3, 0, "R10");
        cs_write_en = 1'b0;
        wr(32'hAA, 1, -1, "R10");
        cs_write_en = 1'b1;
        wr(32'hBB, 1, 8, "R10");
        cs_set(1'b0);

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule